// File: doc/BRIEF.md
# Static Huffman Character Encoder

This block turns characters from a six-letter alphabet into variable-length prefix code words from a fixed Huffman table. A processor drives it through a small register port. It starts a session with a soft reset command, then writes one character at a time. After each write it can read back the code word and its length. Because the table is prefix-free, a decoder can stop at the first complete match; for example, a leading 1 can only mean E.

A packer joins successive code words MSB-first into full output words for storage. When a word fills, it is held until software reads it. While a word is held, the block reports busy and refuses new characters, so no bit is dropped. A flush command pushes out a final partial word, padded with zeros, together with its count of valid bits.

Register map (word addresses on `reg_addr`): 0 control (write), 1 character in (write), 2 last code (read), 3 status (read), 4 packed word (read; a read pops it).

Top module: `huff_enc_top`

## Requirements
- R1: Writing the character bytes 0x45, 0x49, 0x50, 0x4E, 0x53, 0x54 (letters E, I, P, N, S, T) to address 1 makes address 2 read back the code right-aligned in bits [3:0] and the length in bits [10:8]. The codes are E=1, I=0110, P=010, N=000, S=0111 and T=001.
- R2: Writing control bit 0 as 1 (soft reset) clears the partial word, the held word, the error flag and the last code.
- R3: Code words are packed MSB-first with no gaps. The sequence S, E, N, T followed by a flush yields word 0x78200000 with 11 valid bits (0111 1 000 001).
- R4: When 32 bits have gathered, status bit 0 (word ready) sets and the status hold count in bits [13:8] reads 32. The packed word holds steady at address 4 until it is read.
- R5: A character outside the table sets status bit 2 (error) and makes the code length read 0. It adds no bits to the packer.
- R6: A code word that crosses a word boundary completes the current word. Its remaining bits start the next word.
- R7: Writing control bit 1 as 1 (flush) outputs a non-empty partial word padded with zeros and reports its valid bit count in status bits [13:8]. A flush with no pending bits produces no word.
- R8: While a packed word is unread, status bit 1 (busy) is set. A character write in that state is ignored and leaves both the packer and the last code unchanged.
- R9: Reading address 4 while a word is ready clears word ready and busy in the next cycle.
- R10: After the reset input, status, last code and packed word all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe (pops the packed word at address 4) |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |

## Verification
The assertions assume one register operation per cycle, never a write and a read in the same cycle, because the pop-clears check relies on that. They also assume that flush and soft reset are not issued together with a character write. The bench drives each access as a single strobe between falling edges and never raises both strobes at once. Busy is exercised on purpose, by writing while a word is held, rather than avoided.

// File: rtl/huff_enc_pkg.sv
package huff_enc_pkg;

   localparam int SYM_COUNT    = 6;
   localparam int MAX_CODE_LEN = 4;
   localparam int LEN_W        = 3;
   localparam int ADDR_W       = 3;

   typedef struct packed {
      logic [MAX_CODE_LEN-1:0] bits;
      logic [LEN_W-1:0]        len;
   } hcode_t;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL = 3'd0,
      RA_CHAR = 3'd1,
      RA_CODE = 3'd2,
      RA_STAT = 3'd3,
      RA_WORD = 3'd4
   } reg_addr_e;

   // symbol index order: E I N P S T
   function automatic hcode_t sym_code(input int unsigned idx);
      hcode_t c;
      case (idx)
         0:       begin c.bits = 4'b0001; c.len = 3'd1; end
         1:       begin c.bits = 4'b0110; c.len = 3'd4; end
         2:       begin c.bits = 4'b0000; c.len = 3'd3; end
         3:       begin c.bits = 4'b0010; c.len = 3'd3; end
         4:       begin c.bits = 4'b0111; c.len = 3'd4; end
         5:       begin c.bits = 4'b0001; c.len = 3'd3; end
         default: begin c.bits = 4'b0000; c.len = 3'd0; end
      endcase
      return c;
   endfunction

   function automatic logic [7:0] sym_ascii(input int unsigned idx);
      case (idx)
         0:       return 8'h45;
         1:       return 8'h49;
         2:       return 8'h4E;
         3:       return 8'h50;
         4:       return 8'h53;
         5:       return 8'h54;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/huff_lut.sv
module huff_lut
   import huff_enc_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter bit ASCII_IN = 1'b1
) (
   input  logic [CHAR_W-1:0] sym,
   output hcode_t            code,
   output logic              hit
);

   initial begin
      if (ASCII_IN && CHAR_W < 8) $fatal(1, "huff_lut: ASCII input needs CHAR_W >= 8");
      if (CHAR_W < $clog2(SYM_COUNT)) $fatal(1, "huff_lut: CHAR_W too small");
   end

   logic [SYM_COUNT-1:0] match;

   for (genvar g = 0; g < SYM_COUNT; g++) begin : g_match
      if (ASCII_IN) begin : g_ascii
         assign match[g] = (sym == CHAR_W'(sym_ascii(g)));
      end else begin : g_index
         assign match[g] = (sym == CHAR_W'(g));
      end
   end

   always_comb begin
      code = '0;
      for (int i = 0; i < SYM_COUNT; i++) begin
         if (match[i]) code = sym_code(i);
      end
      hit = |match;
   end

endmodule

// File: rtl/huff_packer.sv
module huff_packer #(
   parameter int WORD_W  = 32,
   parameter int MAX_LEN = 4,
   parameter int LEN_W   = 3,
   localparam int CNT_W  = $clog2(WORD_W + 1),
   localparam int WIN_W  = 2 * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               push,
   input  logic [MAX_LEN-1:0] code_bits,
   input  logic [LEN_W-1:0]   code_len,
   input  logic               flush,
   input  logic               pop,
   output logic               word_valid,
   output logic [WORD_W-1:0]  word,
   output logic [CNT_W-1:0]   word_bits
);

   initial begin
      if (WORD_W < MAX_LEN) $fatal(1, "huff_packer: WORD_W below MAX_LEN");
      if ((1 << LEN_W) <= MAX_LEN) $fatal(1, "huff_packer: LEN_W too narrow");
   end

   logic [WORD_W-1:0] acc;
   logic [CNT_W-1:0]  fill;
   logic [WIN_W-1:0]  win;
   logic [CNT_W:0]    sum;
   logic              push_ok;
   int                shamt;

   assign push_ok = push && !word_valid;

   always_comb begin
      sum   = {1'b0, fill} + (CNT_W+1)'(code_len);
      shamt = WIN_W - int'(fill) - int'(code_len);
      win   = {acc, {WORD_W{1'b0}}} | (WIN_W'(code_bits) << shamt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc        <= '0;
         fill       <= '0;
         word       <= '0;
         word_bits  <= '0;
         word_valid <= 1'b0;
      end else if (clr) begin
         acc        <= '0;
         fill       <= '0;
         word       <= '0;
         word_bits  <= '0;
         word_valid <= 1'b0;
      end else begin
         if (pop && word_valid) word_valid <= 1'b0;
         if (push_ok) begin
            if (sum >= (CNT_W+1)'(WORD_W)) begin
               word       <= win[WIN_W-1 -: WORD_W];
               word_bits  <= CNT_W'(WORD_W);
               word_valid <= 1'b1;
               acc        <= win[WORD_W-1:0];
               fill       <= CNT_W'(sum - (CNT_W+1)'(WORD_W));
            end else begin
               acc  <= win[WIN_W-1 -: WORD_W];
               fill <= CNT_W'(sum);
            end
         end else if (flush && !word_valid && fill != '0) begin
            word       <= acc;
            word_bits  <= fill;
            word_valid <= 1'b1;
            acc        <= '0;
            fill       <= '0;
         end
      end
   end

   // R6: the partial fill never reaches a whole word
   a_r6_fill_below_word: assert property (@(posedge clk) disable iff (!rst_n)
      fill < CNT_W'(WORD_W));

   // R4: a held word stays put until popped or cleared
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && !pop && !clr |=> word_valid && $stable(word) && $stable(word_bits));

   // R7: flush reports the pending bit count
   a_r7_flush_count: assert property (@(posedge clk) disable iff (!rst_n)
      flush && !push && !clr && !word_valid && fill != '0 |=> word_valid && word_bits == $past(fill));

endmodule

// File: rtl/huff_enc_top.sv
module huff_enc_top
   import huff_enc_pkg::*;
#(
   parameter int CHAR_W   = 8,
   parameter bit ASCII_IN = 1'b1,
   parameter int WORD_W   = 32,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata
);

   localparam int CNT_W = $clog2(WORD_W + 1);

   initial begin
      if (DATA_W < WORD_W) $fatal(1, "huff_enc_top: DATA_W below WORD_W");
      if (DATA_W < 8 + CNT_W) $fatal(1, "huff_enc_top: DATA_W too small for status");
      if (DATA_W < CHAR_W) $fatal(1, "huff_enc_top: DATA_W below CHAR_W");
   end

   hcode_t            lut_code;
   logic              lut_hit;
   hcode_t            code_q;
   logic              err_q;
   logic              word_valid;
   logic [WORD_W-1:0] word;
   logic [CNT_W-1:0]  word_bits;

   logic wr_ctrl, wr_char, soft_clr, flush_cmd, char_ok, push, pop;

   assign wr_ctrl   = reg_wr && reg_addr == RA_CTRL;
   assign wr_char   = reg_wr && reg_addr == RA_CHAR;
   assign soft_clr  = wr_ctrl && reg_wdata[0];
   assign flush_cmd = wr_ctrl && reg_wdata[1] && !reg_wdata[0];
   assign char_ok   = wr_char && !word_valid;
   assign push      = char_ok && lut_hit;
   assign pop       = reg_rd && !reg_wr && reg_addr == RA_WORD;

   huff_lut #(
      .CHAR_W   (CHAR_W),
      .ASCII_IN (ASCII_IN)
   ) u_lut (
      .sym  (reg_wdata[CHAR_W-1:0]),
      .code (lut_code),
      .hit  (lut_hit)
   );

   huff_packer #(
      .WORD_W  (WORD_W),
      .MAX_LEN (MAX_CODE_LEN),
      .LEN_W   (LEN_W)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (soft_clr),
      .push       (push),
      .code_bits  (lut_code.bits),
      .code_len   (lut_code.len),
      .flush      (flush_cmd),
      .pop        (pop),
      .word_valid (word_valid),
      .word       (word),
      .word_bits  (word_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         err_q  <= 1'b0;
      end else if (soft_clr) begin
         code_q <= '0;
         err_q  <= 1'b0;
      end else if (char_ok) begin
         code_q <= lut_hit ? lut_code : '0;
         if (!lut_hit) err_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CODE: begin
            reg_rdata[MAX_CODE_LEN-1:0] = code_q.bits;
            reg_rdata[8 +: LEN_W]       = code_q.len;
         end
         RA_STAT: begin
            reg_rdata[0]          = word_valid;
            reg_rdata[1]          = word_valid;
            reg_rdata[2]          = err_q;
            reg_rdata[8 +: CNT_W] = word_valid ? word_bits : '0;
         end
         RA_WORD: reg_rdata[WORD_W-1:0] = word_valid ? word : '0;
         default: reg_rdata = '0;
      endcase
   end

   // R5: an unknown character raises the error flag
   a_r5_error_set: assert property (@(posedge clk) disable iff (!rst_n)
      char_ok && !lut_hit && !soft_clr |=> err_q && code_q.len == '0);

   // R9: popping a ready word clears it
   a_r9_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pop && word_valid |=> !word_valid);

   // R8: a character written while busy leaves the last code alone
   a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      wr_char && word_valid |=> $stable(code_q));

endmodule

// File: tb/huff_enc_top_bench.sv
module huff_enc_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   huff_enc_top u_huff_enc_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   localparam logic [7:0] CH_E = 8'h45, CH_I = 8'h49, CH_P = 8'h50,
                          CH_N = 8'h4E, CH_S = 8'h53, CH_T = 8'h54;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pop_word(output logic [31:0] d);
      @(negedge clk);
      reg_addr = 3'd4; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic soft_reset();
      wr(3'd0, 32'h1);
   endtask

   task automatic flush();
      wr(3'd0, 32'h2);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd(3'd3, v); chk("R10 status", v, 32'h0);
      rd(3'd2, v); chk("R10 code", v, 32'h0);
      rd(3'd4, v); chk("R10 word", v, 32'h0);
   endtask

   task automatic t_code_table();
      logic [31:0] v;
      logic [7:0]  ch [6]  = '{CH_E, CH_I, CH_P, CH_N, CH_S, CH_T};
      logic [31:0] exp [6] = '{32'h101, 32'h406, 32'h302, 32'h300, 32'h407, 32'h301};
      for (int i = 0; i < 6; i++) begin
         soft_reset();
         wr(3'd1, {24'h0, ch[i]});
         rd(3'd2, v);
         chk("R1 code", v, exp[i]);
      end
      soft_reset();
   endtask

   task automatic t_sent();
      logic [31:0] v;
      wr(3'd1, {24'h0, CH_S}); wr(3'd1, {24'h0, CH_E});
      wr(3'd1, {24'h0, CH_N}); wr(3'd1, {24'h0, CH_T});
      flush();
      rd(3'd3, v); chk("R7 flush status", v, {18'h0, 6'd11, 8'h03});
      pop_word(v); chk("R3 SENT word", v, 32'h78200000);
      rd(3'd3, v); chk("R9 ready cleared", v, 32'h0);
   endtask

   task automatic t_invalid();
      logic [31:0] v;
      wr(3'd1, {24'h0, CH_E});
      wr(3'd1, 32'h41);
      rd(3'd3, v); chk("R5 error bit", v[2], 32'h1);
      rd(3'd2, v); chk("R5 code len zero", v, 32'h0);
      flush();
      rd(3'd3, v); chk("R5 no bits added", v[13:8], 32'd1);
      pop_word(v); chk("R5 word", v, 32'h80000000);
      soft_reset();
      rd(3'd3, v); chk("R2 error cleared", v, 32'h0);
   endtask

   task automatic t_full_and_busy();
      logic [31:0] v;
      for (int i = 0; i < 8; i++) wr(3'd1, {24'h0, CH_S});
      rd(3'd3, v); chk("R4 ready and count", v, {18'h0, 6'd32, 8'h03});
      wr(3'd1, {24'h0, CH_E});
      rd(3'd2, v); chk("R8 code unchanged", v, 32'h407);
      rd(3'd4, v); chk("R4 word held", v, 32'h77777777);
      pop_word(v); chk("R9 popped word", v, 32'h77777777);
      rd(3'd3, v); chk("R9 busy cleared", v[1:0], 32'h0);
      flush();
      rd(3'd3, v); chk("R8 dropped char left no bits", v, 32'h0);
      wr(3'd1, {24'h0, CH_T});
      flush();
      pop_word(v); chk("R7 padded", v, 32'h20000000);
   endtask

   task automatic t_cross();
      logic [31:0] v;
      for (int i = 0; i < 7; i++) wr(3'd1, {24'h0, CH_S});
      wr(3'd1, {24'h0, CH_P});
      rd(3'd3, v); chk("R6 not yet full", v[0], 32'h0);
      wr(3'd1, {24'h0, CH_I});
      pop_word(v); chk("R6 first word", v, 32'h77777774);
      flush();
      rd(3'd3, v); chk("R6 carry count", v[13:8], 32'd3);
      pop_word(v); chk("R6 carry bits", v, 32'hC0000000);
   endtask

   task automatic t_soft_reset();
      logic [31:0] v;
      wr(3'd1, {24'h0, CH_S});
      soft_reset();
      flush();
      rd(3'd3, v); chk("R2 partial cleared", v, 32'h0);
      rd(3'd2, v); chk("R2 code cleared", v, 32'h0);
      for (int i = 0; i < 8; i++) wr(3'd1, {24'h0, CH_S});
      soft_reset();
      rd(3'd3, v); chk("R2 held word cleared", v, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_code_table();
      t_sent();
      t_invalid();
      t_full_and_busy();
      t_cross();
      t_soft_reset();
      repeat (2) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule